// File: doc/BRIEF.md
# Strap-Sampling Suspend Indicator Pin

This block controls one bidirectional board pin that serves two purposes in turn. While the chip leaves reset, the pin is released (output enable low), so an external pull resistor sets its level. That level passes through a two-flop synchroniser. It is captured once, when a sample counter expires, and becomes the power-switching mode: a high strap selects gang mode and a low strap selects individual mode. The captured mode is held until the next reset, and a valid flag marks it.

After a longer, separately parameterised delay, the block turns the pin into an output. The pin then reports whether the hub is running normally or is globally suspended. The strap decides the polarity. In gang mode the pin is low in normal operation and high in suspend. In individual mode the pin is high in normal operation and low in suspend. The polarity is chosen so that the pin's idle level agrees with the external pull. Both delays are cycle counts, so a simulation can shorten them. With a 100 MHz clock, 2 000 cycles give the 20 µs strap window and 5 000 000 cycles give the 50 ms turnaround.

Top module: `strap_suspend_pin`

## Requirements
- R1: While rst_n is low, pin_oe, pin_out, mode_valid and gang_mode are all 0.
- R2: pin_oe stays 0 for the first OUTPUT_CYCLES-1 rising clock edges after rst_n goes high, and is 1 from edge OUTPUT_CYCLES onward until the next reset.
- R3: mode_valid is 0 for the first SAMPLE_CYCLES-1 rising edges after reset release and 1 from edge SAMPLE_CYCLES onward. At that point gang_mode equals the level pin_in has held since reset release (1 = gang mode, 0 = individual mode).
- R4: Once mode_valid is 1, changes on pin_in do not change gang_mode until the next reset.
- R5: With pin_oe at 1 and gang_mode at 1, pin_out equals suspend_req: 0 in normal operation and 1 while suspended.
- R6: With pin_oe at 1 and gang_mode at 0, pin_out is the inverse of suspend_req: 1 in normal operation and 0 while suspended.
- R7: While pin_oe is 0, pin_out is 0 whatever suspend_req is.
- R8: A new reset during output mode clears every output. The strap is then sampled again, so a different strap level gives the other polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Level read back from the pad |
| suspend_req | input | 1 | High while the hub is globally suspended |
| pin_out | output | 1 | Level driven onto the pad when enabled |
| pin_oe | output | 1 | Pad output enable; 0 leaves the pin as an input |
| gang_mode | output | 1 | Captured strap: 1 gang, 0 individual |
| mode_valid | output | 1 | High once gang_mode has been captured |

## Verification
The hardest condition to reach from the ports is a strap level that differs from the pin's later level. In the real system the pad never changes after the capture point, so a wrong design that keeps tracking the pin would look correct. The stimulus therefore holds a chosen level through the strap window, flips pin_in right after mode_valid rises, and then checks both the captured mode and the output polarity. A reset issued in output mode, with the opposite strap applied, shows that the capture is repeated.

// File: rtl/strap_suspend_pin.sv
module strap_suspend_pin #(
  parameter int SAMPLE_CYCLES = 2000,
  parameter int OUTPUT_CYCLES = 5000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  input  logic suspend_req,
  output logic pin_out,
  output logic pin_oe,
  output logic gang_mode,
  output logic mode_valid
);

  localparam int CW = $clog2(OUTPUT_CYCLES + 1);
  localparam logic [CW-1:0] SAMPLE_AT = CW'(SAMPLE_CYCLES - 1);
  localparam logic [CW-1:0] TURN_AT   = CW'(OUTPUT_CYCLES - 1);
  localparam logic [CW-1:0] CNT_TOP   = CW'(OUTPUT_CYCLES);

  logic [CW-1:0] age;
  logic [1:0]    sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], pin_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age <= '0;
    else if (age != CNT_TOP) age <= age + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gang_mode  <= 1'b0;
      mode_valid <= 1'b0;
    end else if (!mode_valid && age == SAMPLE_AT) begin
      gang_mode  <= sync_q[1];
      mode_valid <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pin_oe <= 1'b0;
    else if (age == TURN_AT) pin_oe <= 1'b1;
  end

  assign pin_out = pin_oe & (suspend_req ^ ~gang_mode);

endmodule

// File: rtl/strap_suspend_pin_chk.sv
module strap_suspend_pin_chk #(
  parameter int SAMPLE_CYCLES = 2000,
  parameter int OUTPUT_CYCLES = 5000000
) (
  input logic clk,
  input logic rst_n,
  input logic pin_in,
  input logic suspend_req,
  input logic pin_out,
  input logic pin_oe,
  input logic gang_mode,
  input logic mode_valid
);

  localparam int CW = $clog2(OUTPUT_CYCLES + 1);
  logic [CW-1:0] edges;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          edges <= '0;
    else if (edges != CW'(OUTPUT_CYCLES)) edges <= edges + 1'b1;
  end

  // R2
  oe_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe == (edges >= CW'(OUTPUT_CYCLES)));

  // R3
  valid_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid == (edges >= CW'(SAMPLE_CYCLES)));

  // R4
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid |=> mode_valid && $stable(gang_mode));

  // R5
  gang_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && gang_mode) |-> pin_out == suspend_req);

  // R6
  indiv_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && !gang_mode) |-> pin_out != suspend_req);

  // R7
  quiet_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> !pin_out);

endmodule

bind strap_suspend_pin strap_suspend_pin_chk #(
  .SAMPLE_CYCLES(SAMPLE_CYCLES),
  .OUTPUT_CYCLES(OUTPUT_CYCLES)
) i_chk (
  .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .suspend_req(suspend_req),
  .pin_out(pin_out), .pin_oe(pin_oe), .gang_mode(gang_mode),
  .mode_valid(mode_valid)
);

// File: tb/test_strap_suspend_pin.sv
module test_strap_suspend_pin;
  localparam int SMP = 8;
  localparam int OUTC = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_in = 1'b0;
  logic suspend_req = 1'b0;
  logic pin_out, pin_oe, gang_mode, mode_valid;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  strap_suspend_pin #(.SAMPLE_CYCLES(SMP), .OUTPUT_CYCLES(OUTC)) i_strap_suspend_pin (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .suspend_req(suspend_req),
    .pin_out(pin_out), .pin_oe(pin_oe), .gang_mode(gang_mode),
    .mode_valid(mode_valid)
  );

  // {strap, flip pin after capture, suspend during input phase}
  localparam logic [2:0] VEC [4] = '{3'b100, 3'b000, 3'b111, 3'b011};

  task automatic check(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic start(input logic strap);
    @(negedge clk);
    rst_n = 1'b0;
    pin_in = strap;
    repeat (2) @(negedge clk);
    check("R1 oe", pin_oe, 1'b0);
    check("R1 out", pin_out, 1'b0);
    check("R1 valid", mode_valid, 1'b0);
    check("R1 mode", gang_mode, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic run_vec(input logic strap, input logic flip, input logic sus);
    start(strap);
    suspend_req = sus;
    repeat (SMP - 1) @(negedge clk);
    check("R3 valid early", mode_valid, 1'b0);
    @(negedge clk);
    check("R3 valid", mode_valid, 1'b1);
    check("R3 mode", gang_mode, strap);
    if (flip) pin_in = ~strap;
    check("R7 quiet", pin_out, 1'b0);
    repeat (OUTC - SMP - 1) @(negedge clk);
    check("R2 oe early", pin_oe, 1'b0);
    check("R7 quiet late", pin_out, 1'b0);
    @(negedge clk);
    check("R2 oe", pin_oe, 1'b1);
    check("R4 mode held", gang_mode, strap);
    suspend_req = 1'b0;
    #1;
    check(strap ? "R5 normal" : "R6 normal", pin_out, ~strap);
    suspend_req = 1'b1;
    #1;
    check(strap ? "R5 suspend" : "R6 suspend", pin_out, strap);
    repeat (3) @(negedge clk);
    check("R2 oe stays", pin_oe, 1'b1);
    check("R4 mode later", gang_mode, strap);
    suspend_req = 1'b0;
  endtask

  initial begin
    foreach (VEC[i]) run_vec(VEC[i][2], VEC[i][1], VEC[i][0]);
    // R8: reset in output mode with the opposite strap
    run_vec(1'b1, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    pin_in = 1'b0;
    #1;
    check("R8 oe cleared", pin_oe, 1'b0);
    check("R8 valid cleared", mode_valid, 1'b0);
    check("R8 out cleared", pin_out, 1'b0);
    run_vec(1'b0, 1'b0, 1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule